// File: doc/BRIEF.md
# Multi-match OS timer core

This block is an operating-system timer. A 32-bit counter advances by one on every clock and can be reloaded from a register bus. Four base compare registers are each checked against the counter. When the counter equals a compare value, that channel's pending bit is latched. A neighbouring block supplies match pulses for eight further channels. Their pending bits sit in the same status word, above the base bits.

Software enables channels through a 12-bit enable register and acknowledges events by writing ones to the status register. Each base channel drives its own interrupt line. The eight extra channels share one combined line. A watchdog arm bit turns a channel-3 match into a single reset-request pulse for the reset controller outside the block.

The bus is a single-cycle word-indexed port. Read data and the error flag are combinational on the request, and writes land on the clock edge that ends the request cycle.

Top module: `ostimer_core`

## Requirements
- R1: After reset the counter is 0, all four compare registers read 0xFFFFFFFF, and enable, status and watchdog read 0. All interrupt lines and reset_req are low.
- R2: The counter rises by exactly one per clock and wraps at 2^32. Word index 4 reads the current count.
- R3: A write to word index 4 loads the written value. A read in the cycle after the write returns that value, and counting resumes from it.
- R4: Word indices 0 to 3 hold compare values for channels 0 to 3. Status bit i is set by the clock edge at which the counter equals compare value i, and it can be read from the next cycle.
- R5: Word index 5 is the enable register. A write stores only bits 11:0, and bits 31:12 read as 0.
- R6: Word index 6 is the status register. A write clears every bit that is written as one and is pending. It leaves all other bits alone and never sets a bit. If a new event lands on the same edge as a clear of that bit, the event wins.
- R7: irq_base[i] is high exactly while status bit i and enable bit i are both set, for i in 0 to 3.
- R8: irq_ext is high while any of status bits 11:4 is set together with its enable bit. It stays high until every such enabled pending bit is cleared.
- R9: A high ext_match[j] at a clock edge sets status bit 4+j.
- R10: A write to word index 7 with bit 0 set arms the watchdog. Later writes cannot disarm it, and the register reads back the arm bit. While armed, the first edge where the counter equals compare value 3 makes reset_req high for exactly one cycle, starting in the next cycle. Only one such pulse is produced per reset. Unarmed matches never raise reset_req.
- R11: A request to word index 8 or above raises bus_err in the same cycle and reads as 0. A write there changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Request valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| bus_err | output | 1 | Unimplemented index (combinational) |
| ext_match | input | 8 | Match pulses of the extra channels |
| irq_base | output | 4 | Per-channel interrupts, channels 0 to 3 |
| irq_ext | output | 1 | Combined interrupt of channels 4 to 11 |
| reset_req | output | 1 | One-cycle watchdog reset request |

## Verification
A wrong count or a mistimed reload shows at the first read of index 4, one cycle after the load. A compare off by one edge moves the status bit, and its interrupt line, one cycle early or late at the bench's per-cycle polling. A status update that drops the set-wins rule, or that clears bits that were not written, leaves the status word wrong at the very next read. A watchdog that is not sticky or not single-shot shows as a missing or repeated reset_req pulse within a dozen cycles of the match.

// File: rtl/ostmr_pkg.sv
package ostmr_pkg;

  typedef enum logic [2:0] {
    RK_MATCH,
    RK_COUNT,
    RK_ENABLE,
    RK_STATUS,
    RK_WDOG,
    RK_NONE
  } reg_kind_e;

  // Map a word index onto the register kind; compare slots come first.
  function automatic reg_kind_e classify(input int unsigned idx,
                                         input int unsigned nbase);
    if (idx < nbase)          return RK_MATCH;
    else if (idx == nbase)     return RK_COUNT;
    else if (idx == nbase + 1) return RK_ENABLE;
    else if (idx == nbase + 2) return RK_STATUS;
    else if (idx == nbase + 3) return RK_WDOG;
    else                       return RK_NONE;
  endfunction

endpackage

// File: rtl/ostmr_regbus.sv
module ostmr_regbus
  import ostmr_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4,
  parameter int NUM_BASE = 4,
  parameter int NUM_EV   = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sel,
  input  logic                         wr,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [NUM_BASE*DATA_W-1:0]   match_flat,
  input  logic [DATA_W-1:0]            count,
  input  logic [NUM_EV-1:0]            enable,
  input  logic [NUM_EV-1:0]            status,
  input  logic                         armed,
  output logic [NUM_BASE-1:0]          match_wr,
  output logic                         cnt_ld,
  output logic                         en_wr,
  output logic                         st_wr,
  output logic                         wd_wr,
  output logic [DATA_W-1:0]            rdata,
  output logic                         err
);

  reg_kind_e   kind;
  int unsigned idx;
  logic        wr_go;

  always_comb begin
    idx   = int'(addr);
    kind  = classify(idx, NUM_BASE);
    wr_go = sel && wr && (kind != RK_NONE);
    err   = sel && (kind == RK_NONE);
  end

  always_comb begin
    for (int i = 0; i < NUM_BASE; i++)
      match_wr[i] = wr_go && (kind == RK_MATCH) && (idx == i);
    cnt_ld = wr_go && (kind == RK_COUNT);
    en_wr  = wr_go && (kind == RK_ENABLE);
    st_wr  = wr_go && (kind == RK_STATUS);
    wd_wr  = wr_go && (kind == RK_WDOG);
  end

  always_comb begin
    rdata = '0;
    unique case (kind)
      RK_MATCH: begin
        for (int i = 0; i < NUM_BASE; i++)
          if (idx == i) rdata = match_flat[i*DATA_W +: DATA_W];
      end
      RK_COUNT:  rdata = count;
      RK_ENABLE: rdata[NUM_EV-1:0] = enable;
      RK_STATUS: rdata[NUM_EV-1:0] = status;
      RK_WDOG:   rdata[0] = armed;
      default:   rdata = '0;
    endcase
  end

  // R11: an unimplemented index never reaches a write strobe
  a_r11_err_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !((|match_wr) || cnt_ld || en_wr || st_wr || wd_wr));

endmodule

// File: rtl/ostmr_timebase.sv
module ostmr_timebase #(
  parameter int DATA_W   = 32,
  parameter int NUM_BASE = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cnt_ld,
  input  logic [NUM_BASE-1:0]        match_wr,
  input  logic [DATA_W-1:0]          wdata,
  output logic [DATA_W-1:0]          count,
  output logic [NUM_BASE*DATA_W-1:0] match_flat,
  output logic [NUM_BASE-1:0]        hit
);

  localparam logic [DATA_W-1:0] MATCH_RST = '1;

  function automatic logic [DATA_W-1:0] next_count(input logic [DATA_W-1:0] c);
    return c + DATA_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (cnt_ld) count <= wdata;
    else             count <= next_count(count);
  end

  for (genvar g = 0; g < NUM_BASE; g++) begin : g_cmp
    logic [DATA_W-1:0] value_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           value_q <= MATCH_RST;
      else if (match_wr[g]) value_q <= wdata;
    end
    assign match_flat[g*DATA_W +: DATA_W] = value_q;
    assign hit[g] = (count == value_q);
  end

  // R2: free counting advances by one
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_ld |=> (count == $past(count) + DATA_W'(1)));
  // R3: a load lands unchanged
  a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_ld |=> (count == $past(wdata)));

endmodule

// File: rtl/ostmr_events.sv
module ostmr_events #(
  parameter int NUM_BASE = 4,
  parameter int NUM_EXT  = 8,
  parameter int NUM_EV   = NUM_BASE + NUM_EXT
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_BASE-1:0] hit,
  input  logic [NUM_EXT-1:0]  ext_match,
  input  logic                en_wr,
  input  logic                st_wr,
  input  logic [NUM_EV-1:0]   wdata_ev,
  output logic [NUM_EV-1:0]   enable,
  output logic [NUM_EV-1:0]   status,
  output logic [NUM_EV-1:0]   set_vec,
  output logic [NUM_BASE-1:0] irq_base,
  output logic                irq_ext
);

  // Only bits both written and pending are removed; new events win.
  function automatic logic [NUM_EV-1:0] w1c_next(input logic [NUM_EV-1:0] cur,
                                                 input logic [NUM_EV-1:0] wv,
                                                 input logic              do_wr,
                                                 input logic [NUM_EV-1:0] set);
    logic [NUM_EV-1:0] drop;
    drop = do_wr ? (wv & cur) : '0;
    return (cur & ~drop) | set;
  endfunction

  logic [NUM_EXT-1:0] ext_active;

  assign set_vec = {ext_match, hit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     enable <= '0;
    else if (en_wr) enable <= wdata_ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= w1c_next(status, wdata_ev, st_wr, set_vec);
  end

  assign irq_base   = status[NUM_BASE-1:0] & enable[NUM_BASE-1:0];
  assign ext_active = status[NUM_EV-1:NUM_BASE] & enable[NUM_EV-1:NUM_BASE];
  assign irq_ext    = |ext_active;

  // R4 / R9: every event reaches its status bit
  a_r4_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((status & $past(set_vec)) == $past(set_vec)));
  // R6: written-and-unset bits are gone after a status write
  a_r6_clears: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr |=> ((status & $past(wdata_ev & ~set_vec)) == '0));
  // R6: without an event no status bit rises
  a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !(|set_vec) |=> ((status & ~$past(status)) == '0));
  // R8: the combined line only falls after a status or enable write
  a_r8_ext_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_ext) |-> ($past(st_wr) || $past(en_wr)));

endmodule

// File: rtl/ostmr_wdog.sv
module ostmr_wdog (
  input  logic clk,
  input  logic rst_n,
  input  logic wd_wr,
  input  logic wd_bit,
  input  logic trip_hit,
  output logic armed,
  output logic reset_req
);

  logic fired;
  logic trip;

  assign trip = armed && trip_hit && !fired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      fired     <= 1'b0;
      reset_req <= 1'b0;
    end else begin
      if (wd_wr && wd_bit) armed <= 1'b1;
      if (trip)            fired <= 1'b1;
      reset_req <= trip;
    end
  end

  // R10: single-cycle pulse
  a_r10_single: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);
  // R10: arming cannot be undone
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed);
  // R10: a pulse needs an armed match one cycle earlier
  a_r10_cause: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> ($past(armed) && $past(trip_hit)));

endmodule

// File: rtl/ostimer_core.sv
module ostimer_core #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4,
  parameter int NUM_BASE = 4,
  parameter int NUM_EXT  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                bus_err,
  input  logic [NUM_EXT-1:0]  ext_match,
  output logic [NUM_BASE-1:0] irq_base,
  output logic                irq_ext,
  output logic                reset_req
);

  localparam int NUM_EV  = NUM_BASE + NUM_EXT;
  localparam int WDOG_CH = NUM_BASE - 1;

  logic [NUM_BASE*DATA_W-1:0] match_flat;
  logic [DATA_W-1:0]          count;
  logic [NUM_EV-1:0]          enable;
  logic [NUM_EV-1:0]          status;
  logic [NUM_EV-1:0]          set_vec;
  logic [NUM_BASE-1:0]        match_wr;
  logic [NUM_BASE-1:0]        hit;
  logic                       cnt_ld, en_wr, st_wr, wd_wr, armed;

  ostmr_regbus #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_BASE(NUM_BASE), .NUM_EV(NUM_EV)
  ) u_bus (
    .clk(clk), .rst_n(rst_n), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
    .match_flat(match_flat), .count(count), .enable(enable), .status(status),
    .armed(armed), .match_wr(match_wr), .cnt_ld(cnt_ld), .en_wr(en_wr),
    .st_wr(st_wr), .wd_wr(wd_wr), .rdata(bus_rdata), .err(bus_err)
  );

  ostmr_timebase #(.DATA_W(DATA_W), .NUM_BASE(NUM_BASE)) u_time (
    .clk(clk), .rst_n(rst_n), .cnt_ld(cnt_ld), .match_wr(match_wr),
    .wdata(bus_wdata), .count(count), .match_flat(match_flat), .hit(hit)
  );

  ostmr_events #(.NUM_BASE(NUM_BASE), .NUM_EXT(NUM_EXT), .NUM_EV(NUM_EV)) u_ev (
    .clk(clk), .rst_n(rst_n), .hit(hit), .ext_match(ext_match),
    .en_wr(en_wr), .st_wr(st_wr), .wdata_ev(bus_wdata[NUM_EV-1:0]),
    .enable(enable), .status(status), .set_vec(set_vec),
    .irq_base(irq_base), .irq_ext(irq_ext)
  );

  ostmr_wdog u_wd (
    .clk(clk), .rst_n(rst_n), .wd_wr(wd_wr), .wd_bit(bus_wdata[0]),
    .trip_hit(hit[WDOG_CH]), .armed(armed), .reset_req(reset_req)
  );

  // R7: a base line never fires without its enable
  a_r7_gated: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_base & ~enable[NUM_BASE-1:0]) == '0));

endmodule

// File: tb/sim_ostimer_core.sv
module sim_ostimer_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        err;
  logic [7:0]  ext = '0;
  logic [3:0]  irq_base;
  logic        irq_ext, reset_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  ostimer_core u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .bus_err(err), .ext_match(ext),
    .irq_base(irq_base), .irq_ext(irq_ext), .reset_req(reset_req)
  );

  // {index, write data, expected read, expected error}
  localparam logic [68:0] VEC [0:9] = '{
    {4'd5,  32'hFFFF_FFFF, 32'h0000_0FFF, 1'b0},
    {4'd5,  32'h1234_5A5A, 32'h0000_0A5A, 1'b0},
    {4'd0,  32'h1234_5678, 32'h1234_5678, 1'b0},
    {4'd1,  32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b0},
    {4'd2,  32'h0700_0000, 32'h0700_0000, 1'b0},
    {4'd3,  32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0},
    {4'd8,  32'h0000_5555, 32'h0000_0000, 1'b1},
    {4'd15, 32'h0000_AAAA, 32'h0000_0000, 1'b1},
    {4'd7,  32'h0000_0000, 32'h0000_0000, 1'b0},
    {4'd5,  32'h0000_0000, 32'h0000_0000, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d, output logic e);
    sel = 1'b1; we = 1'b0; addr = a;
    #1;
    d = rdata; e = err;
    sel = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic        e;
    int          pulses;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(4'd4, d, e); chk("R1 counter", d, 32'h0);
    for (int i = 0; i < 4; i++) begin
      rd(4'(i), d, e); chk("R1 compare", d, 32'hFFFF_FFFF);
    end
    rd(4'd5, d, e); chk("R1 enable", d, 0);
    rd(4'd6, d, e); chk("R1 status", d, 0);
    rd(4'd7, d, e); chk("R1 watchdog", d, 0);
    chk("R1 outputs", {26'd0, irq_base, irq_ext, reset_req}, 0);

    // R5 R11 table walk
    for (int k = 0; k < 10; k++) begin
      wr(VEC[k][68:65], VEC[k][64:33]);
      rd(VEC[k][68:65], d, e);
      chk("R5/R11 table read", d, VEC[k][32:1]);
      chk("R5/R11 table err", {31'd0, e}, {31'd0, VEC[k][0]});
    end

    // R3 load then R2 counting
    wr(4'd4, 32'd100);
    rd(4'd4, d, e); chk("R3 load", d, 32'd100);
    repeat (5) @(negedge clk);
    rd(4'd4, d, e); chk("R2 count", d, 32'd105);
    wr(4'd4, 32'hFFFF_FFFE);
    repeat (3) @(negedge clk);
    rd(4'd4, d, e); chk("R2 wrap", d, 32'd1);

    // R4 R7 compare timing
    wr(4'd0, 32'd1010);
    wr(4'd1, 32'd1005);
    wr(4'd5, 32'hFFF);
    wr(4'd6, 32'hFFF);
    wr(4'd4, 32'd1000);
    for (int k = 1; k <= 11; k++) begin
      @(negedge clk);
      rd(4'd6, d, e);
      chk("R4 status timing", d, ((k >= 6) ? 32'h2 : 32'h0) | ((k >= 11) ? 32'h1 : 32'h0));
    end
    chk("R7 irq lines", {28'd0, irq_base}, 32'h3);

    // R6 clear only written-and-pending
    wr(4'd6, 32'h6);
    rd(4'd6, d, e); chk("R6 partial clear", d, 32'h1);
    chk("R7 after clear", {28'd0, irq_base}, 32'h1);
    wr(4'd5, 32'hFFE);
    rd(4'd6, d, e); chk("R7 status kept", d, 32'h1);
    chk("R7 disabled line", {28'd0, irq_base}, 32'h0);
    wr(4'd5, 32'hFFF);
    wr(4'd6, 32'hFFF);
    rd(4'd6, d, e); chk("R6 full clear", d, 32'h0);
    // R6 event on the clearing edge wins
    wr(4'd4, 32'd1009);
    wr(4'd6, 32'h1);
    rd(4'd6, d, e); chk("R6 set wins", d, 32'h1);
    wr(4'd6, 32'hFFF);

    // R9 R8 extra channels
    @(negedge clk); ext = 8'h05;
    @(negedge clk); ext = 8'h00;
    rd(4'd6, d, e); chk("R9 ext status", d, 32'h050);
    chk("R8 combined high", {31'd0, irq_ext}, 1);
    wr(4'd6, 32'h010);
    rd(4'd6, d, e); chk("R8 one left", d, 32'h040);
    chk("R8 still high", {31'd0, irq_ext}, 1);
    wr(4'd6, 32'h040);
    chk("R8 drops", {31'd0, irq_ext}, 0);
    wr(4'd5, 32'hDFF);
    @(negedge clk); ext = 8'h20;
    @(negedge clk); ext = 8'h00;
    rd(4'd6, d, e); chk("R9 ext bit 9", d, 32'h200);
    chk("R8 masked", {31'd0, irq_ext}, 0);
    wr(4'd5, 32'hFFF);
    chk("R8 unmasked", {31'd0, irq_ext}, 1);
    wr(4'd6, 32'h200);

    // R11 bad write leaves state alone
    wr(4'd9, 32'hFFFF_FFFF);
    rd(4'd5, d, e); chk("R11 enable kept", d, 32'hFFF);
    rd(4'd6, d, e); chk("R11 status kept", d, 32'h0);
    rd(4'd0, d, e); chk("R11 compare kept", d, 32'd1010);

    // R10 watchdog
    wr(4'd3, 32'd3000);
    wr(4'd4, 32'd2990);
    pulses = 0;
    for (int k = 0; k < 14; k++) begin
      @(negedge clk);
      if (reset_req) pulses++;
    end
    chk("R10 unarmed no pulse", pulses, 0);
    wr(4'd7, 32'h1);
    wr(4'd7, 32'h0);
    rd(4'd7, d, e); chk("R10 sticky arm", d, 32'h1);
    wr(4'd4, 32'd2990);
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      chk("R10 pulse timing", {31'd0, reset_req}, (k == 11) ? 32'd1 : 32'd0);
    end
    wr(4'd4, 32'd2990);
    pulses = 0;
    for (int k = 0; k < 14; k++) begin
      @(negedge clk);
      if (reset_req) pulses++;
    end
    chk("R10 single shot", pulses, 0);

    finish_run();
  end

endmodule